// File: doc/BRIEF.md
# Standby Bus Wake-Up Detector

This block sits behind the low-power bus comparator of a CAN front end and is active only while the front end is in its low-power standby state. It samples a digitized bus-dominant level once per clock. A wake request is reported only for a dominant phase that starts with a fresh recessive-to-dominant change and then outlasts a minimum filter time. The request is reported by pulling the standby receive output low, and a sticky wake-pending flag is set at the same time.

A second and much longer limit guards against a bus that stays dominant. Once the dominant phase outlasts the timeout, the receive output returns high. It stays high until the bus goes recessive again, so a shorted or clamped bus cannot hold a wake request forever.

The block does not change the operating mode. The host sees the request and leaves standby itself. When the standby flag drops, all internal state is cleared. Both limits are parameters counted in clock cycles, and the counters saturate instead of wrapping.

Top module: `stby_wake_det`

## Requirements
- R1: After reset, and on every clock edge that samples `standby_i` low, the next cycle shows `rxd_o` = 1 and `wake_pend_o` = 0, whatever `bus_dom_i` does.
- R2: A dominant phase counts only if `bus_dom_i` was sampled 0 (recessive) in standby on the edge before it. A bus that is already dominant when standby is entered raises no request until it has gone recessive and dominant again.
- R3: If `bus_dom_i` is sampled 1 on FILT_CYC+1 consecutive edges after such a change, `rxd_o` is 0 in the cycle after the last of them. A dominant run of only FILT_CYC edges leaves `rxd_o` at 1.
- R4: A single recessive sample during the filter time discards the run. The following dominant phase has to meet R3 again from its own start.
- R5: After a wake, `rxd_o` stays 0 while the bus stays dominant, up to TOUT_CYC dominant edges in total. On dominant edge TOUT_CYC+1 it returns to 1, and it stays 1 however long the bus remains dominant.
- R6: Once a wake has been reported, the first recessive sample returns `rxd_o` to 1 in the next cycle, and `wake_pend_o` stays 1.
- R7: `wake_pend_o` rises in the same cycle as `rxd_o` falls and holds until `standby_i` is sampled low. When that happens, `rxd_o` is also forced to 1 in the next cycle.
- R8: After a timeout, a recessive sample followed by a new dominant run of FILT_CYC+1 edges raises a wake again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| standby_i | input | 1 | High while the front end is in standby |
| bus_dom_i | input | 1 | Digitized bus level from the low-power comparator, 1 = dominant |
| rxd_o | output | 1 | Standby receive level, 0 = wake request |
| wake_pend_o | output | 1 | Sticky flag set on a confirmed wake, cleared when standby ends |

## Verification
The assertions assume that `bus_dom_i` and `standby_i` are already synchronous to `clk` and stable around each rising edge. They also assume TOUT_CYC is larger than FILT_CYC, so that the window check on dominant run length holds. The bench meets these assumptions by changing its inputs only on falling edges and by building the design with a short filter and a longer timeout. It counts every dominant run in whole cycles, so each expected output change falls on a known edge.

// File: rtl/wkd_pkg.sv
// Shared types for the standby wake-up detector.
package wkd_pkg;
    // Detector phase while in standby.
    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,  // no dominant phase being tracked
        WK_FILT  = 2'd1,  // dominant, minimum time not yet met
        WK_WAKE  = 2'd2,  // wake reported, receive output low
        WK_STUCK = 2'd3   // dominant too long, request withdrawn
    } wk_state_t;
endpackage

// File: rtl/wkd_edge.sv
// Recessive-to-dominant change detector.
// Assumes: bus_dom is synchronous to clk. The recessive history is
// forgotten outside standby, so a bus that is already dominant on entry
// produces no change.
module wkd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic bus_dom,
    output logic rise
);
    logic was_rec_q;

    // Remember whether the previous standby sample was recessive.
    always_ff @(posedge clk) begin
        if (!rst_n) was_rec_q <= 1'b0;
        else        was_rec_q <= standby && !bus_dom;
    end

    assign rise = standby && bus_dom && was_rec_q;
endmodule

// File: rtl/wkd_sat_cnt.sv
// Saturating up-counter with synchronous clear.
// Assumes: clear has priority over increment, and MAX fits in W bits.
module wkd_sat_cnt #(
    parameter int MAX = 100000,
    parameter int W   = $clog2(MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = W'(MAX);

    // Count up on inc, hold at TOP, return to zero on clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)           cnt <= '0;
        else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wkd_ctrl.sv
// Wake state machine: filter phase, wake report, stuck-dominant release.
// Assumes: dom_cnt holds the number of dominant samples since the
// recessive-to-dominant change (it reads 0 in IDLE), and TOUT_CYC > FILT_CYC.
module wkd_ctrl
    import wkd_pkg::*;
#(
    parameter int FILT_CYC = 300,
    parameter int TOUT_CYC = 100000,
    parameter int W        = $clog2(TOUT_CYC + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         standby,
    input  logic         bus_dom,
    input  logic         rise,
    input  logic [W-1:0] dom_cnt,
    output wk_state_t    state,
    output logic         pend
);
    localparam logic [W-1:0] FILT_LIM = W'(FILT_CYC);
    localparam logic [W-1:0] TOUT_LIM = W'(TOUT_CYC);

    wk_state_t nxt;

    // Next-state choice from the bus level and the dominant run length.
    always_comb begin
        nxt = state;
        unique case (state)
            WK_IDLE:  if (rise) nxt = WK_FILT;
            WK_FILT:  if (!bus_dom) nxt = WK_IDLE;
                      else if (dom_cnt >= FILT_LIM) nxt = WK_WAKE;
            WK_WAKE:  if (!bus_dom) nxt = WK_IDLE;
                      else if (dom_cnt >= TOUT_LIM) nxt = WK_STUCK;
            WK_STUCK: if (!bus_dom) nxt = WK_IDLE;
            default:  nxt = WK_IDLE;
        endcase
        if (!standby) nxt = WK_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WK_IDLE;
        else        state <= nxt;
    end

    // Sticky pending flag: set on entering WAKE, cleared outside standby.
    always_ff @(posedge clk) begin
        if (!rst_n || !standby)                   pend <= 1'b0;
        else if (nxt == WK_WAKE && state != WK_WAKE) pend <= 1'b1;
    end
endmodule

// File: rtl/stby_wake_det.sv
// Standby bus wake-up detector top.
// Assumes: standby_i and bus_dom_i are synchronous to clk. FILT_CYC and
// TOUT_CYC are cycle counts with TOUT_CYC > FILT_CYC.
module stby_wake_det
    import wkd_pkg::*;
#(
    parameter int FILT_CYC = 300,
    parameter int TOUT_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby_i,
    input  logic bus_dom_i,
    output logic rxd_o,
    output logic wake_pend_o
);
    localparam int CW = $clog2(TOUT_CYC + 1);

    logic          rise;
    logic [CW-1:0] dom_cnt;
    logic          cnt_clr;
    wk_state_t     state;

    wkd_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .standby (standby_i),
        .bus_dom (bus_dom_i),
        .rise    (rise)
    );

    // The run counter stays at zero unless a tracked dominant phase is live.
    assign cnt_clr = !standby_i || !bus_dom_i || (state == WK_IDLE && !rise);

    wkd_sat_cnt #(.MAX(TOUT_CYC), .W(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (1'b1),
        .cnt   (dom_cnt)
    );

    wkd_ctrl #(.FILT_CYC(FILT_CYC), .TOUT_CYC(TOUT_CYC), .W(CW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .standby (standby_i),
        .bus_dom (bus_dom_i),
        .rise    (rise),
        .dom_cnt (dom_cnt),
        .state   (state),
        .pend    (wake_pend_o)
    );

    assign rxd_o = (state != WK_WAKE);
endmodule

// File: rtl/stby_wake_det_chk.sv
// Property checker for stby_wake_det, bound to every instance.
// Assumes: inputs change away from the rising edge. It keeps its own count
// of consecutive dominant standby samples to check the two time windows.
module stby_wake_det_chk #(
    parameter int FILT_CYC = 300,
    parameter int TOUT_CYC = 100000
) (
    input logic clk,
    input logic rst_n,
    input logic standby_i,
    input logic bus_dom_i,
    input logic rxd_o,
    input logic wake_pend_o
);
    localparam int RW = $clog2(TOUT_CYC + 2);
    localparam logic [RW-1:0] RTOP = RW'(TOUT_CYC + 1);

    logic [RW-1:0] run_q;
    logic          live_q;

    // Count consecutive dominant samples taken in standby, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !standby_i || !bus_dom_i) run_q <= '0;
        else if (run_q != RTOP)                 run_q <= run_q + 1'b1;
    end

    // Mark the cycles that follow at least one edge out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_i |=> (rxd_o && !wake_pend_o));                                 // R1
    AST_FALL_AFTER_DOM: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        $fell(rxd_o) |-> ($past(bus_dom_i) && $past(standby_i)));                 // R2
    AST_FILT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        $fell(rxd_o) |-> (run_q >= RW'(FILT_CYC + 1)));                           // R3
    AST_TOUT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !rxd_o |-> (run_q <= RW'(TOUT_CYC)));                                     // R5
    AST_REC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rxd_o && !bus_dom_i) |=> rxd_o);                                        // R6
    AST_LOW_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        !rxd_o |-> wake_pend_o);                                                  // R7
    AST_PEND_WITH_WAKE: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        $rose(wake_pend_o) |-> $fell(rxd_o));                                     // R7
endmodule

bind stby_wake_det stby_wake_det_chk #(.FILT_CYC(FILT_CYC), .TOUT_CYC(TOUT_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .standby_i   (standby_i),
    .bus_dom_i   (bus_dom_i),
    .rxd_o       (rxd_o),
    .wake_pend_o (wake_pend_o)
);

// File: tb/sim_stby_wake_det.sv
// Directed bench for stby_wake_det: inputs change on falling edges and
// outputs are sampled on falling edges.
module sim_stby_wake_det;
    localparam int FILT = 4;
    localparam int TOUT = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standby_i = 1'b0;
    logic bus_dom_i = 1'b0;
    logic rxd_o;
    logic wake_pend_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    stby_wake_det #(.FILT_CYC(FILT), .TOUT_CYC(TOUT)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .standby_i   (standby_i),
        .bus_dom_i   (bus_dom_i),
        .rxd_o       (rxd_o),
        .wake_pend_o (wake_pend_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic dom(input int n);
        bus_dom_i = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic rec(input int n);
        bus_dom_i = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic fresh_standby();
        standby_i = 1'b0;
        rec(1);
        standby_i = 1'b1;
        rec(2);
    endtask

    task automatic t_reset();
        chk("R1", "rxd after reset", rxd_o, 1'b1);
        chk("R1", "pend after reset", wake_pend_o, 1'b0);
        standby_i = 1'b0;
        rec(1);
        dom(10);
        chk("R1", "rxd outside standby", rxd_o, 1'b1);
        chk("R1", "pend outside standby", wake_pend_o, 1'b0);
    endtask

    task automatic t_filter();
        fresh_standby();
        dom(FILT);
        chk("R3", "rxd after FILT dominant", rxd_o, 1'b1);
        chk("R3", "pend after FILT dominant", wake_pend_o, 1'b0);
        rec(2);
        dom(FILT + 1);
        chk("R3", "rxd after FILT+1 dominant", rxd_o, 1'b0);
        chk("R7", "pend set with wake", wake_pend_o, 1'b1);
        rec(1);
        chk("R6", "rxd after recessive", rxd_o, 1'b1);
        chk("R6", "pend held after recessive", wake_pend_o, 1'b1);
        standby_i = 1'b0;
        rec(1);
        chk("R7", "pend cleared by standby exit", wake_pend_o, 1'b0);
    endtask

    task automatic t_glitch();
        fresh_standby();
        dom(3);
        rec(1);
        dom(3);
        chk("R4", "rxd after split run", rxd_o, 1'b1);
        dom(2);
        chk("R4", "rxd after rerun completes", rxd_o, 1'b0);
    endtask

    task automatic t_timeout();
        fresh_standby();
        dom(TOUT);
        chk("R5", "rxd at TOUT dominant", rxd_o, 1'b0);
        dom(1);
        chk("R5", "rxd at TOUT+1 dominant", rxd_o, 1'b1);
        dom(2 * TOUT);
        chk("R5", "rxd on long stuck bus", rxd_o, 1'b1);
        rec(1);
        dom(FILT + 1);
        chk("R8", "rxd rewake after timeout", rxd_o, 1'b0);
    endtask

    task automatic t_entry();
        standby_i = 1'b0;
        dom(3);
        standby_i = 1'b1;
        dom(3 * FILT);
        chk("R2", "rxd with bus dominant at entry", rxd_o, 1'b1);
        chk("R2", "pend with bus dominant at entry", wake_pend_o, 1'b0);
        rec(1);
        dom(FILT + 1);
        chk("R2", "rxd after fresh change", rxd_o, 1'b0);
        standby_i = 1'b0;
        dom(1);
        chk("R7", "rxd forced high on exit", rxd_o, 1'b1);
        chk("R7", "pend cleared on exit", wake_pend_o, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_filter();
        t_glitch();
        t_timeout();
        t_entry();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule